// File: doc/BRIEF.md
# Access Size and Burst Translator

This block sits between a wide slave port (able to carry 64-bit and 128-bit accesses) and a 32-bit master port. It takes one access description at a time: direction, single or burst, access size, burst length, start address and a prefetchable flag. From that description it emits the transfer sequence the master port must issue. Each transfer carries a size, an address and a sequential/nonsequential tag. Where the rules call for it, idle BUSY cycles are placed between transfers. The block also reports how many transfers the sequence holds.

Wide accesses are split into runs of 32-bit transfers whose length is computed from the access. Read bursts to prefetchable space are stretched to the end of the enclosing 32-byte line. Narrow read bursts to non-prefetchable space keep their size and length, with a BUSY cycle between beats. Moving data and handling bus protocol timing belong to the surrounding logic.

Top module: `burst_xlate`

## Requirements
- R1: `cmd_ready` is high whenever no sequence is running. A description is taken on a rising edge with `cmd_valid` and `cmd_ready` both high. The first transfer appears in the following cycle, and `cmd_ready` stays low until the cycle in which `done` is high.
- R2: A read burst with `cmd_pref`=1 becomes 32-bit transfers (size code 2). They start at the address rounded down to 4 bytes and number 8 minus address bits [4:2], so the last one ends on a 32-byte boundary.
- R3: A read burst with `cmd_pref`=0 and size code 0, 1 or 2 keeps its size code and its beat count `cmd_len`. It starts at the address rounded down to the access size.
- R4: In the R3 case exactly one BUSY cycle (`xfer_busy`=1, `xfer_valid`=0) separates consecutive transfers. No other case produces BUSY cycles.
- R5: A read burst with `cmd_pref`=0 and size code 3 (8 bytes) or 4 (16 bytes) becomes `cmd_len` × bytes / 4 transfers of 32 bits.
- R6: A single access (`cmd_burst`=0, read or write) of size code 0 to 2 becomes one transfer of the same size at the address rounded down to that size. `cmd_len` is ignored.
- R7: A single access of size code 3 or 4 becomes bytes / 4 transfers of 32 bits from the address rounded down to 4.
- R8: A write burst becomes 32-bit transfers numbering ceil(`cmd_len` × bytes / 4), from the address rounded down to 4.
- R9: The first transfer of a sequence has `xfer_seq`=0 and every later one `xfer_seq`=1. Each address is the previous one plus the transfer's byte count (2 to the power of the size code).
- R10: `done` is high for exactly one cycle, the cycle after the last transfer. `beat_count` shows the sequence's transfer count from its first transfer cycle until the next description is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A description is offered |
| cmd_ready | output | 1 | Block can take a description |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_burst | input | 1 | 1 = burst, 0 = single |
| cmd_size | input | 3 | Size code: bytes = 2**code, codes 0 to 4 |
| cmd_len | input | LEN_W | Burst beat count, 1 or more |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_pref | input | 1 | Target region is prefetchable |
| xfer_valid | output | 1 | A transfer is presented this cycle |
| xfer_busy | output | 1 | A BUSY cycle is presented this cycle |
| xfer_seq | output | 1 | 1 = sequential, 0 = nonsequential |
| xfer_size | output | 3 | Transfer size code |
| xfer_addr | output | ADDR_W | Transfer address |
| beat_count | output | LEN_W+3 | Transfers in the current sequence |
| done | output | 1 | One-cycle pulse after the last transfer |

## Verification
The first transfer is due one cycle after the accepting edge. Each later transfer follows one cycle after the one before, or two cycles after it when a BUSY cycle lies between them. `done` and the return of `cmd_ready` come one cycle after the last transfer. For every description the bench builds the expected per-cycle stream from the requirements. It compares that stream against the outputs at each falling edge, starting with the cycle after acceptance. Sampling mid-cycle keeps every comparison clear of the registers' update edge.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [2:0] {
    SZ_BYTE  = 3'd0,
    SZ_HALF  = 3'd1,
    SZ_WORD  = 3'd2,
    SZ_DWORD = 3'd3,
    SZ_QWORD = 3'd4
  } xsize_e;

  localparam int WORD_LG = 2;  // log2 of master-side word bytes
  localparam int LINE_LG = 5;  // log2 of prefetch line bytes
  localparam int LINE_WORDS = 1 << (LINE_LG - WORD_LG);
endpackage

// File: rtl/bt_planner.sv
module bt_planner
  import bt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  localparam int CNT_W = LEN_W + 3
) (
  input  logic              i_write,
  input  logic              i_burst,
  input  logic [2:0]        i_size,
  input  logic [LEN_W-1:0]  i_len,
  input  logic [ADDR_W-1:0] i_addr,
  input  logic              i_pref,
  output logic [2:0]        o_size,
  output logic [CNT_W-1:0]  o_count,
  output logic [ADDR_W-1:0] o_addr,
  output logic              o_gap
);
  localparam int TMP_W = LEN_W + 5;

  function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a,
                                                   input logic [2:0] lg);
    logic [ADDR_W-1:0] m;
    m = '1;
    m = m << lg;
    return a & m;
  endfunction

  // ceil(beats * 2**size / 4)
  function automatic logic [CNT_W-1:0] words_of(input logic [LEN_W-1:0] beats,
                                                input logic [2:0] sz);
    logic [TMP_W-1:0] b;
    b = TMP_W'(beats) << sz;
    b = b + TMP_W'(3);
    b = b >> WORD_LG;
    return CNT_W'(b);
  endfunction

  // words left up to the end of the current line
  function automatic logic [CNT_W-1:0] line_rest(input logic [ADDR_W-1:0] a);
    return CNT_W'(LINE_WORDS) - CNT_W'(a[LINE_LG-1:WORD_LG]);
  endfunction

  logic narrow;
  logic [LEN_W-1:0] beats_eff;
  assign narrow    = (i_size <= SZ_WORD);
  assign beats_eff = i_burst ? i_len : LEN_W'(1);

  always_comb begin
    o_gap = 1'b0;
    if (!i_write && i_burst && i_pref) begin
      o_size  = SZ_WORD;
      o_count = line_rest(i_addr);
      o_addr  = align_down(i_addr, 3'(WORD_LG));
    end else if (!i_write && i_burst && narrow) begin
      o_size  = i_size;
      o_count = CNT_W'(i_len);
      o_addr  = align_down(i_addr, i_size);
      o_gap   = 1'b1;
    end else if (!i_burst && narrow) begin
      o_size  = i_size;
      o_count = CNT_W'(1);
      o_addr  = align_down(i_addr, i_size);
    end else begin
      o_size  = SZ_WORD;
      o_count = words_of(beats_eff, i_size);
      o_addr  = align_down(i_addr, 3'(WORD_LG));
    end
  end
endmodule

// File: rtl/bt_sequencer.sv
module bt_sequencer #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        p_size,
  input  logic [CNT_W-1:0]  p_count,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic              p_gap,
  output logic              running,
  output logic              xfer_valid,
  output logic              xfer_busy,
  output logic              xfer_seq,
  output logic [2:0]        xfer_size,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [CNT_W-1:0]  beat_count,
  output logic              done
);
  logic              active_q, gap_q, first_q, gap_en_q, done_q;
  logic [CNT_W-1:0]  left_q, count_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        sz_q;

  // named internal events
  logic              beat_fire, gap_fire, last_beat;
  logic [ADDR_W-1:0] step;

  assign beat_fire = active_q && !gap_q;
  assign gap_fire  = active_q && gap_q;
  assign last_beat = beat_fire && (left_q == CNT_W'(1));
  assign step      = ADDR_W'(1) << sz_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      gap_q    <= 1'b0;
      first_q  <= 1'b0;
      gap_en_q <= 1'b0;
      done_q   <= 1'b0;
      left_q   <= '0;
      count_q  <= '0;
      addr_q   <= '0;
      sz_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        active_q <= 1'b1;
        gap_q    <= 1'b0;
        first_q  <= 1'b1;
        gap_en_q <= p_gap;
        left_q   <= p_count;
        count_q  <= p_count;
        addr_q   <= p_addr;
        sz_q     <= p_size;
      end else if (last_beat) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end else if (beat_fire) begin
        left_q  <= left_q - CNT_W'(1);
        addr_q  <= addr_q + step;
        first_q <= 1'b0;
        gap_q   <= gap_en_q;
      end else if (gap_fire) begin
        gap_q <= 1'b0;
      end
    end
  end

  assign running    = active_q;
  assign xfer_valid = beat_fire;
  assign xfer_busy  = gap_fire;
  assign xfer_seq   = !first_q;
  assign xfer_size  = sz_q;
  assign xfer_addr  = addr_q;
  assign beat_count = count_q;
  assign done       = done_q;

  a_r1_first_beat_next: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> xfer_valid && !xfer_seq);
  a_r2_nonzero_plan: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> p_count != '0);
  a_r4_busy_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_valid && xfer_busy));
  a_r4_busy_then_beat: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |=> xfer_valid && xfer_seq);
  a_r9_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_seq && $past(xfer_valid)) |->
      xfer_addr == $past(xfer_addr) + (ADDR_W'(1) << xfer_size));
  a_r10_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(xfer_valid) && !running);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/burst_xlate.sv
module burst_xlate
  import bt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  localparam int CNT_W = LEN_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic              cmd_burst,
  input  logic [2:0]        cmd_size,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_pref,
  output logic              xfer_valid,
  output logic              xfer_busy,
  output logic              xfer_seq,
  output logic [2:0]        xfer_size,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [CNT_W-1:0]  beat_count,
  output logic              done
);
  logic              accept, running;
  logic [2:0]        pl_size;
  logic [CNT_W-1:0]  pl_count;
  logic [ADDR_W-1:0] pl_addr;
  logic              pl_gap;

  assign cmd_ready = !running;
  assign accept    = cmd_valid && cmd_ready;

  bt_planner #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_plan (
    .i_write (cmd_write),
    .i_burst (cmd_burst),
    .i_size  (cmd_size),
    .i_len   (cmd_len),
    .i_addr  (cmd_addr),
    .i_pref  (cmd_pref),
    .o_size  (pl_size),
    .o_count (pl_count),
    .o_addr  (pl_addr),
    .o_gap   (pl_gap)
  );

  bt_sequencer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .p_size     (pl_size),
    .p_count    (pl_count),
    .p_addr     (pl_addr),
    .p_gap      (pl_gap),
    .running    (running),
    .xfer_valid (xfer_valid),
    .xfer_busy  (xfer_busy),
    .xfer_seq   (xfer_seq),
    .xfer_size  (xfer_size),
    .xfer_addr  (xfer_addr),
    .beat_count (beat_count),
    .done       (done)
  );

  a_r1_ready_low_while_running: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid || xfer_busy) |-> !cmd_ready);
  a_r6_single_narrow_one_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmd_burst && cmd_size <= SZ_WORD) |=> beat_count == CNT_W'(1));
endmodule

// File: tb/test_burst_xlate.sv
module test_burst_xlate;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 8;
  localparam int CNT_W  = LEN_W + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, cmd_burst = 1'b0, cmd_pref = 1'b0;
  logic [2:0] cmd_size = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic cmd_ready, xfer_valid, xfer_busy, xfer_seq, done;
  logic [2:0] xfer_size;
  logic [ADDR_W-1:0] xfer_addr;
  logic [CNT_W-1:0] beat_count;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  burst_xlate #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_burst_xlate (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_burst(cmd_burst), .cmd_size(cmd_size),
    .cmd_len(cmd_len), .cmd_addr(cmd_addr), .cmd_pref(cmd_pref),
    .xfer_valid(xfer_valid), .xfer_busy(xfer_busy), .xfer_seq(xfer_seq),
    .xfer_size(xfer_size), .xfer_addr(xfer_addr), .beat_count(beat_count),
    .done(done)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // Expected cycle item: {kind(2): 1=beat 2=busy, seq, size(3), addr(32)}
  task automatic run(input string tag, input bit wr, input bit bu, input int sz,
                     input int len, input longint addr, input bit pf);
    logic [37:0] exp_q[$];
    longint bytes, a0, tb;
    int tsz, n;
    bit gap;
    bytes = longint'(1) << sz;
    gap = 0;
    if (!wr && bu && pf) begin                  // R2
      tsz = 2; a0 = addr - (addr % 4); n = 8 - int'((addr / 4) % 8);
    end else if (!wr && bu && sz <= 2) begin    // R3, R4
      tsz = sz; a0 = addr - (addr % bytes); n = len; gap = 1;
    end else if (!bu && sz <= 2) begin          // R6
      tsz = sz; a0 = addr - (addr % bytes); n = 1;
    end else begin                              // R5, R7, R8
      tsz = 2; a0 = addr - (addr % 4);
      n = int'(((bu ? longint'(len) : 64'd1) * bytes + 3) / 4);
    end
    tb = longint'(1) << tsz;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({2'd1, (i > 0), 3'(tsz), 32'(a0 + i * tb)});
      if (gap && i < n - 1) exp_q.push_back({2'd2, 1'b0, 3'd0, 32'd0});
    end

    @(negedge clk);
    chk({tag, " R1 ready before accept"}, 64'(cmd_ready), 64'd1);
    cmd_valid = 1'b1; cmd_write = wr; cmd_burst = bu; cmd_size = 3'(sz);
    cmd_len = LEN_W'(len); cmd_addr = ADDR_W'(addr); cmd_pref = pf;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_len = 8'hA5;
    chk({tag, " R10 beat_count"}, 64'(beat_count), 64'(n));
    chk({tag, " R1 ready low while running"}, 64'(cmd_ready), 64'd0);
    foreach (exp_q[k]) begin
      if (exp_q[k][37:36] == 2'd1)
        chk({tag, " R9 beat"}, {xfer_valid, xfer_busy, xfer_seq, xfer_size, xfer_addr},
            {1'b1, 1'b0, exp_q[k][35:0]});
      else
        chk({tag, " R4 busy cycle"}, {xfer_valid, xfer_busy}, 2'b01);
      chk({tag, " R10 no early done"}, 64'(done), 64'd0);
      @(negedge clk);
    end
    chk({tag, " R10 done pulse"}, {xfer_valid, xfer_busy, done, cmd_ready}, 4'b0011);
    @(negedge clk);
    chk({tag, " R10 done one cycle"}, 64'(done), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", {cmd_ready, xfer_valid, xfer_busy, done}, 4'b1000);

    run("R2 pref mid-line",     0, 1, 2, 4, 'h1004, 1);
    run("R2 pref last word",    0, 1, 3, 2, 'h101E, 1);
    run("R2 pref line start",   0, 1, 0, 1, 'h2000, 1);
    run("R3 R4 half burst",     0, 1, 1, 3, 'h2003, 0);
    run("R3 R4 byte burst",     0, 1, 0, 4, 'h2011, 0);
    run("R3 R4 word len1",      0, 1, 2, 1, 'h2022, 0);
    run("R5 dword read burst",  0, 1, 3, 4, 'h3008, 0);
    run("R5 qword read burst",  0, 1, 4, 2, 'h3010, 0);
    run("R6 single byte write", 1, 0, 0, 9, 'h4001, 0);
    run("R6 single word read",  0, 0, 2, 7, 'h4006, 1);
    run("R7 single qword wr",   1, 0, 4, 3, 'h5000, 0);
    run("R7 single dword rd",   0, 0, 3, 1, 'h5008, 0);
    run("R8 word write burst",  1, 1, 2, 5, 'h6004, 0);
    run("R8 byte write burst",  1, 1, 0, 6, 'h6001, 1);
    run("R8 dword write burst", 1, 1, 3, 3, 'h6010, 0);

    summary();
    $finish;
  end
endmodule